// File: doc/BRIEF.md
# Two-Port Locked Region Guard

This block sits in front of a memory slave that has several request ports (two by default) and coordinates locked sequences between them. Each port offers a request made of a valid/ready handshake, the page number of its address (the address bits above the 4KB offset), a lock flag, a sequence-end flag and an abort strobe. When a port starts a locked sequence, the guard records the 4KB page of that first locked beat in a small per-port ownership table. It then holds the ready line low for any request on another port that targets the same page, and lets requests to other pages through in the same cycle.

Every locked beat accepted while a sequence is open is compared with the recorded page. A beat that strays outside that page raises a one-cycle violation flag for its port. A sequence ends when a locked beat carrying the end flag is accepted, or when the abort strobe arrives. In both cases the table entry is cleared at once, so a stalled request on the other port is granted in the following cycle. The owning port then spends one cycle in a release state before it can claim a page again. Data movement, responses and the memory itself are not part of the block.

Top module: `lrg_guard`

## Requirements
- R1: After a synchronous active-high reset, no port owns a page, every port's ready is high while no request is presented, and every violation flag is low.
- R2: A locked beat (lock=1, end=0) accepted on an idle port claims the page given by its page input. From the next cycle until release, any request on another port with the same page sees ready low.
- R3: While a page is owned, a request on another port to a different page sees ready high in the same cycle.
- R4: A stalled request is not dropped. When the owner's ending locked beat (lock=1, end=1) is accepted at a clock edge, the stalled port's ready is high in the cycle right after that edge.
- R5: After its sequence ends or is aborted, the owning port's ready is low for exactly one cycle (release), and only after that can it claim a new page, so back-to-back sequences never overlap.
- R6: A locked beat accepted by a port with an open sequence whose page differs from the owned page sets that port's violation flag high for exactly the next cycle. In-page beats and beats from idle ports leave it low.
- R7: An abort strobe on a port with an open sequence clears its ownership, so other ports see ready for that page in the next cycle, and the port passes through release. An abort on an idle port has no effect.
- R8: When two ports present requests to the same unowned page in the same cycle and at least one of them is a locked claim from an idle port, the lower-numbered port is granted and the higher-numbered port sees ready low.
- R9: A non-locked request (lock=0) from the owner to its own page sees ready high and neither ends the sequence nor raises a violation.
- R10: A single-beat locked sequence (lock=1 and end=1 on an idle port) claims no page. Other ports may reach that page in the next cycle, and the port passes through release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | NP | Request valid, one bit per port |
| req_page_i | input | NP x (ADDR_W-OFFS_W) | Address bits above the 4KB offset, per port |
| req_lock_i | input | NP | Request belongs to a locked sequence |
| req_last_i | input | NP | Locked beat that ends the sequence |
| req_abort_i | input | NP | Abort the open locked sequence of the port |
| req_ready_o | output | NP | Grant; the request is accepted when valid and ready are both high |
| viol_o | output | NP | Registered one-cycle flag for a locked beat outside the owned page |

## Verification
A stale or missing ownership entry shows up at the ports in the same cycle, as a wrongly low or high ready on the other port for the owned page. A state machine stuck in release or in locked shows within one cycle, as a ready that stays low on the owner or a page that is never freed. A wrong stored page shows one cycle after the next locked beat, as a violation flag that is missing or spurious. Because of this, the bench compares both ready lines and both flags every cycle against its own model. It does so under random traffic over three pages and in directed cases for stall, release, abort, priority and single-beat sequences.

// File: rtl/lrg_pkg.sv
package lrg_pkg;

  // Life cycle of one port's locked sequence.
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOCKED = 2'd1,
    ST_REL    = 2'd2
  } lrg_state_e;

endpackage

// File: rtl/lrg_port_fsm.sv
module lrg_port_fsm
  import lrg_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire_i,
  input  logic          lock_i,
  input  logic          last_i,
  input  logic          abort_i,
  input  logic [TW-1:0] page_i,
  output lrg_state_e    st_o,
  output logic          own_vld_o,
  output logic [TW-1:0] own_page_o,
  output logic          viol_o
);

  lrg_state_e    st_q;
  logic          vld_q;
  logic [TW-1:0] page_q;
  logic          viol_q;

  logic locked_beat;
  logic ends_seq;

  assign locked_beat = fire_i && lock_i;
  assign ends_seq    = locked_beat && last_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      vld_q  <= 1'b0;
      page_q <= '0;
      viol_q <= 1'b0;
    end else begin
      viol_q <= (st_q == ST_LOCKED) && locked_beat && (page_i != page_q);
      case (st_q)
        ST_IDLE: begin
          if (locked_beat) begin
            page_q <= page_i;
            if (last_i) begin
              st_q  <= ST_REL;
              vld_q <= 1'b0;
            end else begin
              st_q  <= ST_LOCKED;
              vld_q <= 1'b1;
            end
          end
        end
        ST_LOCKED: begin
          if (abort_i || ends_seq) begin
            st_q  <= ST_REL;
            vld_q <= 1'b0;
          end
        end
        ST_REL: begin
          st_q  <= ST_IDLE;
          vld_q <= 1'b0;
        end
        default: begin
          st_q  <= ST_IDLE;
          vld_q <= 1'b0;
        end
      endcase
    end
  end

  assign st_o       = st_q;
  assign own_vld_o  = vld_q;
  assign own_page_o = page_q;
  assign viol_o     = viol_q;

endmodule

// File: rtl/lrg_conflict.sv
module lrg_conflict
  import lrg_pkg::*;
#(
  parameter int NP = 2,
  parameter int TW = 4
) (
  input  logic                  [NP-1:0]         valid_i,
  input  logic                  [NP-1:0]         lock_i,
  input  logic                  [NP-1:0][TW-1:0] page_i,
  input  lrg_state_e            [NP-1:0]         st_i,
  input  logic                  [NP-1:0]         own_vld_i,
  input  logic                  [NP-1:0][TW-1:0] own_page_i,
  output logic                  [NP-1:0]         ready_o
);

  logic [NP-1:0] base_ok;
  logic [NP-1:0] claim;

  // Table lookup: a port is held off by a page another port owns,
  // and by its own release cycle.
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      claim[p]   = valid_i[p] && lock_i[p] && (st_i[p] == ST_IDLE);
      base_ok[p] = (st_i[p] != ST_REL);
      for (int q = 0; q < NP; q++) begin
        if (q != p && own_vld_i[q] && (own_page_i[q] == page_i[p]))
          base_ok[p] = 1'b0;
      end
    end
  end

  // Fixed priority between same-cycle requests on one free page when a
  // claim is involved: the lower index wins.
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      ready_o[p] = base_ok[p];
      for (int q = 0; q < NP; q++) begin
        if (q < p && valid_i[q] && base_ok[q] && (page_i[q] == page_i[p]) &&
            (claim[q] || claim[p]))
          ready_o[p] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/lrg_guard.sv
module lrg_guard
  import lrg_pkg::*;
#(
  parameter int NP     = 2,
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 12,
  localparam int TW    = ADDR_W - OFFS_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NP-1:0]         req_valid_i,
  input  logic [NP-1:0][TW-1:0] req_page_i,
  input  logic [NP-1:0]         req_lock_i,
  input  logic [NP-1:0]         req_last_i,
  input  logic [NP-1:0]         req_abort_i,
  output logic [NP-1:0]         req_ready_o,
  output logic [NP-1:0]         viol_o
);

  lrg_state_e [NP-1:0]         st_q;
  logic       [NP-1:0]         own_vld;
  logic       [NP-1:0][TW-1:0] own_page;
  logic       [NP-1:0]         ready;
  logic       [NP-1:0]         fire;

  lrg_conflict #(.NP(NP), .TW(TW)) u_conflict (
    .valid_i    (req_valid_i),
    .lock_i     (req_lock_i),
    .page_i     (req_page_i),
    .st_i       (st_q),
    .own_vld_i  (own_vld),
    .own_page_i (own_page),
    .ready_o    (ready)
  );

  for (genvar p = 0; p < NP; p++) begin : g_port
    assign fire[p] = req_valid_i[p] && ready[p];

    lrg_port_fsm #(.TW(TW)) u_fsm (
      .clk        (clk),
      .rst        (rst),
      .fire_i     (fire[p]),
      .lock_i     (req_lock_i[p]),
      .last_i     (req_last_i[p]),
      .abort_i    (req_abort_i[p]),
      .page_i     (req_page_i[p]),
      .st_o       (st_q[p]),
      .own_vld_o  (own_vld[p]),
      .own_page_o (own_page[p]),
      .viol_o     (viol_o[p])
    );
  end

  assign req_ready_o = ready;

endmodule

// File: rtl/lrg_guard_chk.sv
module lrg_guard_chk
  import lrg_pkg::*;
#(
  parameter int NP = 2,
  parameter int TW = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NP-1:0][TW-1:0] req_page_i,
  input logic [NP-1:0]         req_abort_i,
  input logic [NP-1:0]         req_ready_o,
  input logic [NP-1:0]         viol_o,
  input lrg_state_e [NP-1:0]   st_q,
  input logic [NP-1:0]         own_vld,
  input logic [NP-1:0][TW-1:0] own_page
);

  // R1
  reset_clean_chk: assert property (@(posedge clk)
    $fell(rst) |-> (own_vld == '0 && viol_o == '0));

  for (genvar p = 0; p < NP; p++) begin : g_p
    // R5
    release_stall_chk: assert property (@(posedge clk) disable iff (rst)
      (st_q[p] == ST_REL) |-> !req_ready_o[p]);

    // R5
    release_once_chk: assert property (@(posedge clk) disable iff (rst)
      (st_q[p] == ST_REL) |=> (st_q[p] == ST_IDLE));

    // R6
    viol_origin_chk: assert property (@(posedge clk) disable iff (rst)
      viol_o[p] |-> $past(st_q[p] == ST_LOCKED));

    // R7
    abort_free_chk: assert property (@(posedge clk) disable iff (rst)
      (req_abort_i[p] && st_q[p] == ST_LOCKED) |=> (st_q[p] == ST_REL && !own_vld[p]));

    for (genvar q = 0; q < NP; q++) begin : g_q
      if (q != p) begin : g_pair
        // R2
        owned_block_chk: assert property (@(posedge clk) disable iff (rst)
          (own_vld[q] && own_page[q] == req_page_i[p]) |-> !req_ready_o[p]);

        // R8
        single_owner_chk: assert property (@(posedge clk) disable iff (rst)
          !(own_vld[p] && own_vld[q] && own_page[p] == own_page[q]));
      end
    end
  end

endmodule

bind lrg_guard lrg_guard_chk #(.NP(NP), .TW(TW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_page_i  (req_page_i),
  .req_abort_i (req_abort_i),
  .req_ready_o (req_ready_o),
  .viol_o      (viol_o),
  .st_q        (st_q),
  .own_vld     (own_vld),
  .own_page    (own_page)
);

// File: tb/lrg_guard_tb.sv
`timescale 1ns/1ps
module lrg_guard_tb;

  localparam int NP = 2;
  localparam int TW = 4;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic [NP-1:0]         v, lk, ls, ab;
  logic [NP-1:0][TW-1:0] pg;
  logic [NP-1:0]         rdy, vio;

  int n_chk = 0;
  int n_bad = 0;

  // bench model: 0 idle, 1 locked, 2 release
  int   m_st   [NP];
  bit   m_own  [NP];
  int   m_page [NP];
  bit   m_viol [NP];

  always #10 clk = ~clk;

  lrg_guard #(.NP(NP), .ADDR_W(16), .OFFS_W(12)) u_dut (
    .clk (clk), .rst (rst),
    .req_valid_i (v), .req_page_i (pg), .req_lock_i (lk),
    .req_last_i (ls), .req_abort_i (ab),
    .req_ready_o (rdy), .viol_o (vio)
  );

  function automatic bit base_ok(int p);
    bit ok = (m_st[p] != 2);
    for (int q = 0; q < NP; q++)
      if (q != p && m_own[q] && m_page[q] == int'(pg[p])) ok = 0;
    return ok;
  endfunction

  function automatic bit exp_ready(int p);
    bit r = base_ok(p);
    for (int q = 0; q < p; q++) begin
      bit cq = v[q] && lk[q] && m_st[q] == 0;
      bit cp = v[p] && lk[p] && m_st[p] == 0;
      if (v[q] && base_ok(q) && pg[q] == pg[p] && (cq || cp)) r = 0;
    end
    return r;
  endfunction

  task automatic cmp(string rq, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", rq, got, exp, $time);
    end
  endtask

  // Compare all outputs against the model, then advance the model.
  task automatic step(string rq);
    bit er [NP];
    #2;
    for (int p = 0; p < NP; p++) begin
      er[p] = exp_ready(p);
      cmp({rq, " ready"}, rdy[p], er[p]);
      cmp({rq, " viol"}, vio[p], m_viol[p]);
    end
    for (int p = 0; p < NP; p++) begin
      bit f = v[p] && er[p];
      m_viol[p] = (m_st[p] == 1) && f && lk[p] && (int'(pg[p]) != m_page[p]);
      case (m_st[p])
        0: if (f && lk[p]) begin
             m_page[p] = int'(pg[p]);
             m_st[p]   = ls[p] ? 2 : 1;
             m_own[p]  = !ls[p];
           end
        1: if (ab[p] || (f && lk[p] && ls[p])) begin
             m_st[p] = 2; m_own[p] = 0;
           end
        default: begin m_st[p] = 0; m_own[p] = 0; end
      endcase
    end
  endtask

  task automatic quiet();
    v = '0; lk = '0; ls = '0; ab = '0; pg = '0;
  endtask

  task automatic drv(int p, bit vv, int page, bit l, bit e, bit a);
    v[p] = vv; pg[p] = TW'(page); lk[p] = l; ls[p] = e; ab[p] = a;
  endtask

  task automatic next();
    @(negedge clk);
    quiet();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(20 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c1e));
    quiet();
    for (int p = 0; p < NP; p++) begin
      m_st[p] = 0; m_own[p] = 0; m_page[p] = 0; m_viol[p] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    next(); #2;
    cmp("R1 ready0", rdy[0], 1'b1); cmp("R1 ready1", rdy[1], 1'b1);
    cmp("R1 viol0", vio[0], 1'b0);  cmp("R1 viol1", vio[1], 1'b0);
    step("R1");

    // R2: port 0 claims page 1
    next(); drv(0, 1, 1, 1, 0, 0); step("R2 claim");
    next(); drv(1, 1, 1, 0, 0, 0); step("R2");
    cmp("R2 stall", rdy[1], 1'b0);
    // R3: other page runs
    next(); drv(1, 1, 2, 1, 0, 0); step("R3");
    cmp("R3 pass", rdy[1], 1'b1);
    // port 1 claimed page 2; end it as single next beat
    next(); drv(1, 1, 2, 1, 1, 0); step("R3 end");
    next(); step("R5 gap");
    // R9: owner non-locked access to own page, port 1 stalled
    next(); drv(0, 1, 1, 0, 0, 0); drv(1, 1, 1, 0, 0, 0); step("R9");
    cmp("R9 owner", rdy[0], 1'b1); cmp("R9 stalled", rdy[1], 1'b0);
    // R6: out-of-page locked beat
    next(); drv(0, 1, 3, 1, 0, 0); drv(1, 1, 1, 0, 0, 0); step("R6 stray");
    next(); drv(0, 1, 1, 1, 1, 0); drv(1, 1, 1, 0, 0, 0); step("R6 end");
    cmp("R6 flag", vio[0], 1'b1); cmp("R4 still stalled", rdy[1], 1'b0);
    // R4 / R5: grant next cycle, owner in release
    next(); drv(0, 1, 1, 1, 0, 0); drv(1, 1, 1, 0, 0, 0); step("R4");
    cmp("R4 grant", rdy[1], 1'b1); cmp("R5 release", rdy[0], 1'b0);
    cmp("R6 one cycle", vio[0], 1'b0);
    // R8: port 0 claim beats port 1 same page
    next(); drv(0, 1, 1, 1, 0, 0); drv(1, 1, 1, 0, 0, 0); step("R8 claim");
    cmp("R8 win", rdy[0], 1'b1); cmp("R8 lose", rdy[1], 1'b0);
    // R7: abort frees page
    next(); drv(0, 0, 0, 0, 0, 1); drv(1, 1, 1, 0, 0, 0); step("R7 abort");
    cmp("R7 held", rdy[1], 1'b0);
    next(); drv(1, 1, 1, 0, 0, 0); step("R7 freed");
    cmp("R7 grant", rdy[1], 1'b1); cmp("R7 release", rdy[0], 1'b0);
    next(); step("R7 idle");
    // R8: both claim page 5
    next(); drv(0, 1, 5, 1, 0, 0); drv(1, 1, 5, 1, 0, 0); step("R8 both");
    cmp("R8 p0", rdy[0], 1'b1); cmp("R8 p1", rdy[1], 1'b0);
    next(); drv(0, 0, 0, 0, 0, 1); step("R8 abort");
    next(); step("R8 rel");
    // R10: single-beat locked sequence
    next(); drv(0, 1, 6, 1, 1, 0); step("R10 beat");
    next(); drv(1, 1, 6, 1, 0, 0); step("R10");
    cmp("R10 free", rdy[1], 1'b1);
    // R7: abort on idle port 0 has no effect on its next claim
    next(); drv(0, 1, 7, 0, 0, 1); drv(1, 1, 6, 1, 1, 0); step("R7 idle abort");
    next(); drv(0, 1, 7, 1, 0, 0); step("R7 idle claim");
    cmp("R7 idle ok", rdy[0], 1'b1);
    next(); drv(0, 0, 0, 0, 0, 1); step("R7 cleanup");
    next(); step("R7 cleanup2");

    // random traffic over three pages
    for (int i = 0; i < 3000; i++) begin
      next();
      for (int p = 0; p < NP; p++)
        drv(p, ($urandom % 10) < 6, $urandom % 3, $urandom % 2,
            ($urandom % 4) == 0, ($urandom % 20) == 0);
      step("R2-model random");
    end

    next();
    summary();
    $finish;
  end

endmodule